// File: doc/BRIEF.md
# Dual-Bank Register File with Bank Exchange

This block holds the general-purpose working registers of an 8-bit processor core. It keeps two copies of the accumulator/flag pair and two copies of the six general byte registers. Two select bits, one for the accumulator/flag copies and one for the general copies, decide which copy every read and write reaches. The selects change independently of each other.

An exchange command does not move any data. It inverts a select bit in one clock, so the other copy becomes visible on the very next cycle. Software, or an interrupt entry sequence, can use this to switch to a reserved register context without saving anything to memory. One exchange flips the accumulator/flag copy. The other flips all six general registers at once.

The control logic reads operands through one byte port and one pair port. Both ports are combinational. A single synchronous write port stores either one byte or one 16-bit pair.

Top module: `dual_bank_regfile`

## Requirements
- R1: While `rst_n` is low, both select bits are forced to 0 and `af_bank` and `gen_bank` read 0. Register contents after reset are undefined.
- R2: A byte write (`wr_en`=1, `wr_wide`=0) stores `wr_data[7:0]` into the register that `wr_sel` names. The encoding is 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=F, 7=A. `rd8_data` returns the register that `rd8_sel` names, using the same encoding.
- R3: A pair write (`wr_en`=1, `wr_wide`=1) stores `wr_data[15:8]` into the high register and `wr_data[7:0]` into the low register of pair `wr_sel[1:0]`. The pair encoding is 0=BC, 1=DE, 2=HL, 3=AF. The high byte is B, D, H or A. `wr_sel[2]` is ignored in this mode. `rd16_data` returns {high, low} of pair `rd16_sel`.
- R4: Byte registers and pair halves are the same storage. A pair write is visible through byte reads, and byte writes are visible through pair reads.
- R5: `xchg_af`=1 for one cycle inverts `af_bank` at that clock edge. `gen_bank` and all register contents stay unchanged. With `xchg_af`=0, `af_bank` holds its value.
- R6: `xchg_gen`=1 for one cycle inverts `gen_bank` at that clock edge. All six general registers switch together, and `af_bank` is unchanged. With `xchg_gen`=0, `gen_bank` holds its value.
- R7: The two copies of every register are independent. A write reaches only the copy that the current select picks.
- R8: When an exchange and a write happen in the same cycle, the write lands in the copy that was selected before the exchange.
- R9: Asserting `xchg_af` and `xchg_gen` in the same cycle inverts both selects.
- R10: With `wr_en`=0, `wr_data`, `wr_sel` and `wr_wide` have no effect on any register.
- R11: Reads are combinational. A change of `rd8_sel` or `rd16_sel`, or of a select bit, appears on the read data in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the select bits |
| xchg_af | input | 1 | Invert the accumulator/flag select |
| xchg_gen | input | 1 | Invert the general-set select |
| wr_en | input | 1 | Write strobe |
| wr_wide | input | 1 | 1 = pair write, 0 = byte write |
| wr_sel | input | 3 | Byte register index, or pair index in bits [1:0] |
| wr_data | input | 16 | Write data; the low byte is used for byte writes |
| rd8_sel | input | 3 | Byte read index |
| rd8_data | output | 8 | Byte read data from the selected copy |
| rd16_sel | input | 2 | Pair read index |
| rd16_data | output | 16 | Pair read data {high, low} |
| af_bank | output | 1 | Current accumulator/flag select |
| gen_bank | output | 1 | Current general-set select |

## Verification
The bench fills every register in all four select combinations with values computed from the register index, the copy and the pass number. It then reads every byte and every pair in each combination. A value from the wrong copy, the wrong register, or a swapped pair half therefore shows up as a mismatch.

Walking through the combinations one exchange at a time separates the two select bits. A second pass uses pair writes read back through bytes, which confirms that bytes and pair halves share storage.

Writes issued in the same cycle as an exchange are read back from both copies, which shows whether the write landed in the copy selected before or after the exchange. Writes with the strobe low confirm that nothing changes.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int GEN_REGS = 6;
  localparam int AF_REGS  = 2;
  localparam int ALL_REGS = GEN_REGS + AF_REGS;
  localparam int SEL_W    = $clog2(ALL_REGS);

  typedef enum logic [SEL_W-1:0] {
    IDX_B = 3'd0, IDX_C = 3'd1, IDX_D = 3'd2, IDX_E = 3'd3,
    IDX_H = 3'd4, IDX_L = 3'd5, IDX_F = 3'd6, IDX_A = 3'd7
  } byte_idx_e;

  typedef enum logic [1:0] {
    PR_BC = 2'd0, PR_DE = 2'd1, PR_HL = 2'd2, PR_AF = 2'd3
  } pair_idx_e;

  // high byte of a pair: first-named register
  function automatic logic [SEL_W-1:0] pair_hi(input logic [1:0] p);
    return (p == PR_AF) ? IDX_A : {p, 1'b0};
  endfunction

  // low byte of a pair: second-named register
  function automatic logic [SEL_W-1:0] pair_lo(input logic [1:0] p);
    return (p == PR_AF) ? IDX_F : {p, 1'b1};
  endfunction
endpackage

// File: rtl/bank_sel_ctrl.sv
module bank_sel_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic flip_af,
  input  logic flip_gen,
  output logic af_sel,
  output logic gen_sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af_sel  <= 1'b0;
      gen_sel <= 1'b0;
    end else begin
      if (flip_af)  af_sel  <= ~af_sel;
      if (flip_gen) gen_sel <= ~gen_sel;
    end
  end
endmodule

// File: rtl/wr_decode.sv
module wr_decode
  import regbank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                               wr_en,
  input  logic                               wr_wide,
  input  logic [SEL_W-1:0]                   wr_sel,
  input  logic [2*DATA_W-1:0]                wr_data,
  output logic [ALL_REGS-1:0]                reg_we,
  output logic [ALL_REGS-1:0][DATA_W-1:0]    reg_wd
);
  logic [SEL_W-1:0] hi_idx, lo_idx;

  assign hi_idx = pair_hi(wr_sel[1:0]);
  assign lo_idx = pair_lo(wr_sel[1:0]);

  always_comb begin
    for (int i = 0; i < ALL_REGS; i++) begin
      if (wr_wide) begin
        reg_we[i] = wr_en && ((SEL_W'(i) == hi_idx) || (SEL_W'(i) == lo_idx));
        reg_wd[i] = (SEL_W'(i) == hi_idx) ? wr_data[2*DATA_W-1:DATA_W]
                                          : wr_data[DATA_W-1:0];
      end else begin
        reg_we[i] = wr_en && (SEL_W'(i) == wr_sel);
        reg_wd[i] = wr_data[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/bank_array.sv
module bank_array #(
  parameter int NREG   = 6,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           sel,
  input  logic [NREG-1:0]                we,
  input  logic [NREG-1:0][DATA_W-1:0]    wd,
  output logic [NREG-1:0][DATA_W-1:0]    rd,
  output logic [1:0]                     bank_we
);
  localparam int NBANK = 2;

  logic [NREG-1:0][DATA_W-1:0] bank_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [NREG-1:0][DATA_W-1:0] mem;
    logic                        hit;

    assign hit        = (sel == 1'(b));
    assign bank_we[b] = hit && (|we);
    assign bank_q[b]  = mem;

    always_ff @(posedge clk) begin
      for (int r = 0; r < NREG; r++) begin
        if (hit && we[r]) mem[r] <= wd[r];
      end
    end
  end

  assign rd = bank_q[sel];
endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
  import regbank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  xchg_af,
  input  logic                  xchg_gen,
  input  logic                  wr_en,
  input  logic                  wr_wide,
  input  logic [2:0]            wr_sel,
  input  logic [2*DATA_W-1:0]   wr_data,
  input  logic [2:0]            rd8_sel,
  output logic [DATA_W-1:0]     rd8_data,
  input  logic [1:0]            rd16_sel,
  output logic [2*DATA_W-1:0]   rd16_data,
  output logic                  af_bank,
  output logic                  gen_bank
);
  logic [ALL_REGS-1:0]             reg_we;
  logic [ALL_REGS-1:0][DATA_W-1:0] reg_wd;
  logic [ALL_REGS-1:0][DATA_W-1:0] reg_rd;
  logic [1:0]                      gen_bank_we;
  logic [1:0]                      af_bank_we;

  bank_sel_ctrl u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .flip_af  (xchg_af),
    .flip_gen (xchg_gen),
    .af_sel   (af_bank),
    .gen_sel  (gen_bank)
  );

  wr_decode #(.DATA_W(DATA_W)) u_dec (
    .wr_en   (wr_en),
    .wr_wide (wr_wide),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .reg_we  (reg_we),
    .reg_wd  (reg_wd)
  );

  bank_array #(.NREG(GEN_REGS), .DATA_W(DATA_W)) u_gen (
    .clk     (clk),
    .sel     (gen_bank),
    .we      (reg_we[GEN_REGS-1:0]),
    .wd      (reg_wd[GEN_REGS-1:0]),
    .rd      (reg_rd[GEN_REGS-1:0]),
    .bank_we (gen_bank_we)
  );

  bank_array #(.NREG(AF_REGS), .DATA_W(DATA_W)) u_af (
    .clk     (clk),
    .sel     (af_bank),
    .we      (reg_we[ALL_REGS-1:GEN_REGS]),
    .wd      (reg_wd[ALL_REGS-1:GEN_REGS]),
    .rd      (reg_rd[ALL_REGS-1:GEN_REGS]),
    .bank_we (af_bank_we)
  );

  assign rd8_data  = reg_rd[rd8_sel];
  assign rd16_data = {reg_rd[pair_hi(rd16_sel)], reg_rd[pair_lo(rd16_sel)]};
endmodule

// File: rtl/regfile_chk.sv
module regfile_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                xchg_af,
  input logic                xchg_gen,
  input logic                wr_en,
  input logic                wr_wide,
  input logic [2:0]          wr_sel,
  input logic [2*DATA_W-1:0] wr_data,
  input logic [1:0]          rd16_sel,
  input logic [2*DATA_W-1:0] rd16_data,
  input logic                af_bank,
  input logic                gen_bank,
  input logic [1:0]          gen_bank_we,
  input logic [1:0]          af_bank_we
);
  // R1
  reset_banks_chk: assert property (@(posedge clk)
    !rst_n |=> (!af_bank && !gen_bank));

  // R5
  af_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_af |=> (af_bank != $past(af_bank)));

  // R5
  af_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xchg_af |=> $stable(af_bank));

  // R6
  gen_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_gen |=> (gen_bank != $past(gen_bank)));

  // R6
  gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xchg_gen |=> $stable(gen_bank));

  // R7
  gen_one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gen_bank_we));

  // R7
  af_one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(af_bank_we));

  // R10
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (gen_bank_we == 2'b00 && af_bank_we == 2'b00));

  // R3
  pair_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_wide && (wr_sel[1:0] == rd16_sel) && !xchg_af && !xchg_gen)
    |=> ((rd16_sel != $past(rd16_sel)) || (rd16_data == $past(wr_data))));
endmodule

bind dual_bank_regfile regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xchg_af     (xchg_af),
  .xchg_gen    (xchg_gen),
  .wr_en       (wr_en),
  .wr_wide     (wr_wide),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .rd16_sel    (rd16_sel),
  .rd16_data   (rd16_data),
  .af_bank     (af_bank),
  .gen_bank    (gen_bank),
  .gen_bank_we (gen_bank_we),
  .af_bank_we  (af_bank_we)
);

// File: tb/dual_bank_regfile_test.sv
module dual_bank_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xchg_af = 1'b0, xchg_gen = 1'b0;
  logic        wr_en = 1'b0, wr_wide = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [15:0] wr_data = 16'h0;
  logic [2:0]  rd8_sel = 3'd0;
  logic [1:0]  rd16_sel = 2'd0;
  logic [7:0]  rd8_data;
  logic [15:0] rd16_data;
  logic        af_bank, gen_bank;

  int nchk = 0, nerr = 0;

  // bench model: mg[copy][0..5]=B,C,D,E,H,L ; ma[copy][0]=F, [1]=A
  logic [7:0] mg [2][6];
  logic [7:0] ma [2][2];
  int mab = 0, mgb = 0;

  always #10 clk = ~clk;

  dual_bank_regfile uut (
    .clk(clk), .rst_n(rst_n), .xchg_af(xchg_af), .xchg_gen(xchg_gen),
    .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd8_sel(rd8_sel), .rd8_data(rd8_data), .rd16_sel(rd16_sel),
    .rd16_data(rd16_data), .af_bank(af_bank), .gen_bank(gen_bank)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input int i, input logic [7:0] v);
    if (i < 6) mg[mgb][i] = v;
    else       ma[mab][i-6] = v;
  endtask

  function automatic logic [7:0] exp8(input int s);
    return (s < 6) ? mg[mgb][s] : ma[mab][s-6];
  endfunction

  // pair p: high/low indices per R3 encoding
  function automatic logic [15:0] exp16(input int p);
    if (p == 3) return {ma[mab][1], ma[mab][0]};
    return {mg[mgb][2*p], mg[mgb][2*p+1]};
  endfunction

  // one clock: inputs driven now, model updated with pre-edge selects (R8)
  task automatic step(input logic xa, input logic xg, input logic we,
                      input logic wide, input logic [2:0] sel, input logic [15:0] d);
    xchg_af = xa; xchg_gen = xg; wr_en = we; wr_wide = wide; wr_sel = sel; wr_data = d;
    @(posedge clk);
    if (we) begin
      if (wide) begin
        if (sel[1:0] == 2'd3) begin put(7, d[15:8]); put(6, d[7:0]); end
        else begin put(2*sel[1:0], d[15:8]); put(2*sel[1:0]+1, d[7:0]); end
      end else put(sel, d[7:0]);
    end
    if (xa) mab = 1 - mab;
    if (xg) mgb = 1 - mgb;
    @(negedge clk);
    xchg_af = 0; xchg_gen = 0; wr_en = 0; wr_wide = 0;
  endtask

  task automatic read_all(input string tag);
    for (int s = 0; s < 8; s++) begin
      rd8_sel = 3'(s); #1;
      check(tag, {8'h0, rd8_data}, {8'h0, exp8(s)});
    end
    for (int p = 0; p < 4; p++) begin
      rd16_sel = 2'(p); #1;
      check(tag, rd16_data, exp16(p));
    end
  endtask

  task automatic check_banks(input string tag);
    check(tag, {15'h0, af_bank}, 16'(mab));
    check(tag, {15'h0, gen_bank}, 16'(mgb));
  endtask

  initial begin
    #(200000 * 20);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; check_banks("R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    #1; check_banks("R1 after reset");

    // pass 0: byte writes in all four combinations (R2, R7)
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 8; s++)
        step(0, 0, 1, 0, 3'(s), {8'hEE, 8'(s*37 + c*91 + 5)});
      // walk the combinations: gen, af, gen, af (R5, R6)
      if (c % 2 == 0) step(0, 1, 0, 0, 3'd0, 16'h0);
      else            step(1, 0, 0, 0, 3'd0, 16'h0);
      check_banks((c % 2 == 0) ? "R6 gen exchange" : "R5 af exchange");
    end
    for (int c = 0; c < 4; c++) begin
      read_all("R2 R7 R11 byte sweep");
      if (c % 2 == 0) step(0, 1, 0, 0, 3'd0, 16'h0);
      else            step(1, 0, 0, 0, 3'd0, 16'h0);
      check_banks("R5 R6 walk");
    end

    // pass 1: pair writes, read back as bytes and pairs (R3, R4)
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 4; p++)
        step(0, 0, 1, 1, {c[0], 2'(p)}, 16'(p*4111 + c*1234 + 16'h0A0B));
      read_all("R3 R4 pair sweep");
      step(c[0], ~c[0], 0, 0, 3'd0, 16'h0);
    end

    // both exchanges together (R9)
    step(1, 1, 0, 0, 3'd0, 16'h0);
    check_banks("R9 double exchange");
    read_all("R9 contents after double exchange");

    // ignored write data with strobe low (R10)
    xchg_af = 0; xchg_gen = 0; wr_en = 0; wr_wide = 1; wr_sel = 3'd2; wr_data = 16'hDEAD;
    @(posedge clk); @(negedge clk);
    wr_wide = 0; wr_sel = 3'd7; wr_data = 16'h00BE;
    @(posedge clk); @(negedge clk);
    read_all("R10 strobe low");

    // write in same cycle as exchange goes to old copy (R8)
    step(0, 1, 1, 0, 3'd0, 16'h0077);
    read_all("R8 gen new copy untouched");
    step(0, 1, 0, 0, 3'd0, 16'h0);
    rd8_sel = 3'd0; #1;
    check("R8 gen old copy got byte", {8'h0, rd8_data}, 16'h0077);
    step(1, 0, 1, 1, 3'd3, 16'h5AC3);
    read_all("R8 af new copy untouched");
    step(1, 0, 0, 0, 3'd0, 16'h0);
    rd16_sel = 2'd3; #1;
    check("R8 af old copy got pair", rd16_data, 16'h5AC3);

    // combinational read of a changing select (R11)
    rd8_sel = 3'd7; #1;
    check("R11 comb read A", {8'h0, rd8_data}, {8'h0, exp8(7)});
    rd8_sel = 3'd1; #1;
    check("R11 comb read C", {8'h0, rd8_data}, {8'h0, exp8(1)});

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule